// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Selector

This block decides, for every processor in the system, which pending interrupt is the most urgent one it should be told about. It receives the state of an interrupt distributor as plain inputs: the per-source enable bits, a pending vector for each CPU, and 8-bit priorities. Sources below a banked boundary have a separate priority per CPU. Sources at or above the boundary share one priority across all CPUs. It also receives a global distributor enable, and for each CPU an interface enable, a priority mask and a running priority. Register access, acknowledge and end-of-interrupt bookkeeping live elsewhere and reach this block only through those inputs.

For each CPU the block first searches all candidates for the smallest priority value, with ties going to the lowest source ID. It then applies two thresholds to the winner. If the winner's priority is above the mask, nothing is reported and the ID output shows the spurious value 1023. If the winner passes the mask, its ID is reported. The request line is raised only when the winner is also strictly more urgent than what the CPU is already running. Both outputs are registered, so the ID and the request change together one clock after the inputs change.

Top module: `irq_prio_select`

## Requirements
- R1: While reset is asserted, every CPU's highest-pending ID reads 1023 and every request line is low from the following clock edge on.
- R2: A source is a candidate for a CPU only when its enable bit is 1 and its pending bit for that CPU (bit `c*NUM_SRC+s` of `pend`) is 1.
- R3: Among candidates, the smallest priority value wins. When several share that value, the lowest source ID wins.
- R4: With no candidate for a CPU, that CPU's ID output is 1023 and its request line is low.
- R5: The winner's ID is reported only when its priority is less than or equal to the CPU's priority mask. Otherwise the ID is 1023 and the request is low.
- R6: The request line is high exactly when an ID is reported and the zero-extended winner priority is strictly below the 9-bit running priority. The idle value 0x100 lets any priority preempt.
- R7: A winner that passes the mask but does not preempt keeps its ID on the output with the request low.
- R8: With the distributor enable low, every CPU shows ID 1023 and a low request.
- R9: With one CPU's interface enable low, that CPU shows ID 1023 and a low request, and the other CPUs are unaffected.
- R10: A source below `BANKED_SRC` uses the priority of its own CPU bank, `prio_bank[(c*BANKED_SRC+s)*8 +: 8]`. A source at or above it uses the shared priority `prio_shared[(s-BANKED_SRC)*8 +: 8]` for all CPUs.
- R11: The outputs reflect the inputs sampled at the preceding rising clock edge. Before that edge, the previous result is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dist_en | input | 1 | Global distributor enable |
| cpu_en | input | NUM_CPU | Per-CPU interface enable |
| src_en | input | NUM_SRC | Per-source enable |
| pend | input | NUM_CPU*NUM_SRC | Pending bits, CPU-major |
| prio_bank | input | NUM_CPU*BANKED_SRC*8 | Banked per-CPU priorities for low sources |
| prio_shared | input | (NUM_SRC-BANKED_SRC)*8 | Shared priorities for high sources |
| prio_mask | input | NUM_CPU*8 | Per-CPU priority mask |
| run_prio | input | NUM_CPU*9 | Per-CPU running priority, 0x100 when idle |
| hp_id | output | NUM_CPU*10 | Per-CPU highest-pending ID, 1023 when none |
| irq_req | output | NUM_CPU | Per-CPU interrupt request |

## Verification
Two kinds of events can land in the same cycle and must be judged together. One is the mask filter, which decides whether an ID is reported at all. The other is the preemption compare, which decides whether the request line is raised. Directed vectors set the winner's priority exactly equal to the mask and exactly equal to the running priority. In those vectors the ID must appear while the request stays low. Random vectors mix masks, running priorities and narrow priority ranges that produce ties. A bench function computes the expected ID and request for each CPU and compares both outputs in the same sampled cycle.

// File: rtl/prio_sel_pkg.sv
// Shared types for the priority selector: the candidate record carried
// through the compare tree and the merge rule that ranks two candidates.
package prio_sel_pkg;

    localparam int ID_W        = 10;
    localparam int PRIO_W      = 8;
    localparam int RUN_W       = PRIO_W + 1;
    localparam int SPURIOUS_ID = 1023;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
    } cand_t;

    // Keep the lower-ID side (lo) unless hi is strictly more urgent.
    function automatic cand_t pick_best(input cand_t lo, input cand_t hi);
        if (hi.valid && (!lo.valid || (hi.prio < lo.prio)))
            return hi;
        return lo;
    endfunction

endpackage

// File: rtl/prio_tree.sv
// Balanced compare-select tree over N candidates.
// Assumes leaf i carries a lower ID than leaf i+1, so ties resolve to the
// lower index. Leaves are padded to a power of two with invalid entries.
module prio_tree
    import prio_sel_pkg::*;
#(
    parameter int N = 64
) (
    input  cand_t leaves [N],
    output cand_t best
);
    localparam int LVL = (N > 1) ? $clog2(N) : 1;
    localparam int NP  = 1 << LVL;

    cand_t nodes [2*NP-1];

    // Leaf layer: heap positions NP-1 .. 2*NP-2.
    for (genvar i = 0; i < NP; i++) begin : g_leaf
        if (i < N) begin : g_real
            assign nodes[NP-1+i] = leaves[i];
        end else begin : g_pad
            assign nodes[NP-1+i] = '0;
        end
    end

    // Internal nodes: node k merges children 2k+1 (lower IDs) and 2k+2.
    for (genvar k = 0; k < NP-1; k++) begin : g_node
        assign nodes[k] = pick_best(nodes[2*k+1], nodes[2*k+2]);
    end

    assign best = nodes[0];
endmodule

// File: rtl/cpu_select.sv
// Selection path for one CPU: gathers candidates with their priority
// (banked or shared), finds the winner, applies the mask and preemption
// thresholds and registers the ID and request together.
// Assumes 0 < BANKED_SRC < NUM_SRC and NUM_SRC <= 1023.
module cpu_select
    import prio_sel_pkg::*;
#(
    parameter int NUM_SRC    = 64,
    parameter int BANKED_SRC = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 active,
    input  logic [NUM_SRC-1:0]                   src_en,
    input  logic [NUM_SRC-1:0]                   pend,
    input  logic [BANKED_SRC*PRIO_W-1:0]         prio_bank,
    input  logic [(NUM_SRC-BANKED_SRC)*PRIO_W-1:0] prio_shared,
    input  logic [PRIO_W-1:0]                    mask,
    input  logic [RUN_W-1:0]                     run,
    output logic [ID_W-1:0]                      hp_id,
    output logic                                 req
);
    cand_t leaves [NUM_SRC];
    cand_t best;
    logic  reported;
    logic  [ID_W-1:0] id_d;
    logic  req_d;

    // Candidate records: banked priority below the boundary, shared above.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cand
        if (s < BANKED_SRC) begin : g_bank
            assign leaves[s] = '{valid: src_en[s] & pend[s],
                                 prio:  prio_bank[s*PRIO_W +: PRIO_W],
                                 id:    ID_W'(s)};
        end else begin : g_shr
            assign leaves[s] = '{valid: src_en[s] & pend[s],
                                 prio:  prio_shared[(s-BANKED_SRC)*PRIO_W +: PRIO_W],
                                 id:    ID_W'(s)};
        end
    end

    prio_tree #(.N(NUM_SRC)) u_tree (
        .leaves (leaves),
        .best   (best)
    );

    // Threshold stage: mask filters reporting, running priority gates request.
    always_comb begin
        reported = active && best.valid && (best.prio <= mask);
        id_d     = reported ? best.id : ID_W'(SPURIOUS_ID);
        req_d    = reported && ({1'b0, best.prio} < run);
    end

    // Output register: ID and request move on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hp_id <= ID_W'(SPURIOUS_ID);
            req   <= 1'b0;
        end else begin
            hp_id <= id_d;
            req   <= req_d;
        end
    end
endmodule

// File: rtl/irq_prio_select.sv
// Top level: one selection path per CPU, each seeing its own pending
// slice, priority bank, mask and running priority, plus the shared
// priorities. A CPU path is active only when both enables are set.
module irq_prio_select
    import prio_sel_pkg::*;
#(
    parameter int NUM_SRC    = 64,
    parameter int NUM_CPU    = 2,
    parameter int BANKED_SRC = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   dist_en,
    input  logic [NUM_CPU-1:0]                     cpu_en,
    input  logic [NUM_SRC-1:0]                     src_en,
    input  logic [NUM_CPU*NUM_SRC-1:0]             pend,
    input  logic [NUM_CPU*BANKED_SRC*PRIO_W-1:0]   prio_bank,
    input  logic [(NUM_SRC-BANKED_SRC)*PRIO_W-1:0] prio_shared,
    input  logic [NUM_CPU*PRIO_W-1:0]              prio_mask,
    input  logic [NUM_CPU*RUN_W-1:0]               run_prio,
    output logic [NUM_CPU*ID_W-1:0]                hp_id,
    output logic [NUM_CPU-1:0]                     irq_req
);
    localparam int BANK_BITS = BANKED_SRC * PRIO_W;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        cpu_select #(
            .NUM_SRC    (NUM_SRC),
            .BANKED_SRC (BANKED_SRC)
        ) u_sel (
            .clk         (clk),
            .rst_n       (rst_n),
            .active      (dist_en & cpu_en[c]),
            .src_en      (src_en),
            .pend        (pend[c*NUM_SRC +: NUM_SRC]),
            .prio_bank   (prio_bank[c*BANK_BITS +: BANK_BITS]),
            .prio_shared (prio_shared),
            .mask        (prio_mask[c*PRIO_W +: PRIO_W]),
            .run         (run_prio[c*RUN_W +: RUN_W]),
            .hp_id       (hp_id[c*ID_W +: ID_W]),
            .req         (irq_req[c])
        );
    end
endmodule

// File: rtl/irq_prio_select_chk.sv
// Property checker for irq_prio_select, attached by bind. It observes the
// top-level ports only, and keeps one registered copy of the candidate set
// so that a reported ID can be traced back to the inputs that produced it.
module irq_prio_select_chk
    import prio_sel_pkg::*;
#(
    parameter int NUM_SRC    = 64,
    parameter int NUM_CPU    = 2,
    parameter int BANKED_SRC = 32
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   dist_en,
    input logic [NUM_CPU-1:0]                     cpu_en,
    input logic [NUM_SRC-1:0]                     src_en,
    input logic [NUM_CPU*NUM_SRC-1:0]             pend,
    input logic [NUM_CPU*BANKED_SRC*PRIO_W-1:0]   prio_bank,
    input logic [(NUM_SRC-BANKED_SRC)*PRIO_W-1:0] prio_shared,
    input logic [NUM_CPU*PRIO_W-1:0]              prio_mask,
    input logic [NUM_CPU*RUN_W-1:0]               run_prio,
    input logic [NUM_CPU*ID_W-1:0]                hp_id,
    input logic [NUM_CPU-1:0]                     irq_req
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
        logic [NUM_SRC-1:0] cand_q;
        logic [ID_W-1:0]    id_c;

        assign id_c = hp_id[c*ID_W +: ID_W];

        // Candidate set as seen at the previous edge.
        always_ff @(posedge clk) cand_q <= src_en & pend[c*NUM_SRC +: NUM_SRC];

        assert_reset_idle_R1: assert property (@(posedge clk)
            !rst_n |=> (id_c == ID_W'(SPURIOUS_ID) && !irq_req[c]));

        assert_id_is_candidate_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (id_c != ID_W'(SPURIOUS_ID)) |->
                ((id_c < ID_W'(NUM_SRC)) && cand_q[id_c[IDX_W-1:0]]));

        assert_req_needs_id_R6: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[c] |-> (id_c != ID_W'(SPURIOUS_ID)));

        assert_dist_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !dist_en |=> (id_c == ID_W'(SPURIOUS_ID) && !irq_req[c]));

        assert_cpu_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !cpu_en[c] |=> (id_c == ID_W'(SPURIOUS_ID) && !irq_req[c]));
    end
endmodule

bind irq_prio_select irq_prio_select_chk #(
    .NUM_SRC    (NUM_SRC),
    .NUM_CPU    (NUM_CPU),
    .BANKED_SRC (BANKED_SRC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dist_en     (dist_en),
    .cpu_en      (cpu_en),
    .src_en      (src_en),
    .pend        (pend),
    .prio_bank   (prio_bank),
    .prio_shared (prio_shared),
    .prio_mask   (prio_mask),
    .run_prio    (run_prio),
    .hp_id       (hp_id),
    .irq_req     (irq_req)
);

// File: tb/irq_prio_select_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random vectors, each
// compared against a reference computed from the requirements.
module irq_prio_select_tb;
    localparam int NS = 64;
    localparam int NC = 2;
    localparam int NB = 32;
    localparam int SP = 1023;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic                    dist_en;
    logic [NC-1:0]           cpu_en;
    logic [NS-1:0]           src_en;
    logic [NC*NS-1:0]        pend;
    logic [NC*NB*8-1:0]      prio_bank;
    logic [(NS-NB)*8-1:0]    prio_shared;
    logic [NC*8-1:0]         prio_mask;
    logic [NC*9-1:0]         run_prio;
    logic [NC*10-1:0]        hp_id;
    logic [NC-1:0]           irq_req;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_prio_select #(.NUM_SRC(NS), .NUM_CPU(NC), .BANKED_SRC(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
        .src_en(src_en), .pend(pend), .prio_bank(prio_bank),
        .prio_shared(prio_shared), .prio_mask(prio_mask), .run_prio(run_prio),
        .hp_id(hp_id), .irq_req(irq_req)
    );

    function automatic int prio_of(int c, int s);
        if (s < NB) return int'(prio_bank[(c*NB+s)*8 +: 8]);
        return int'(prio_shared[(s-NB)*8 +: 8]);
    endfunction

    // Reference from the requirements: expected ID and request for CPU c.
    function automatic void ref_calc(int c, output int eid, output bit ereq);
        int best = SP;
        int bp   = 256;
        eid  = SP;
        ereq = 1'b0;
        for (int s = 0; s < NS; s++) begin
            if (src_en[s] && pend[c*NS+s] && prio_of(c, s) < bp) begin
                bp   = prio_of(c, s);
                best = s;
            end
        end
        if (!(dist_en && cpu_en[c]) || best == SP) return;
        if (bp <= int'(prio_mask[c*8 +: 8])) begin
            eid  = best;
            ereq = (bp < int'(run_prio[c*9 +: 9]));
        end
    endfunction

    task automatic cmp_cpu(int c, int eid, bit ereq, string tag);
        int aid = int'(hp_id[c*10 +: 10]);
        n_vec++;
        if (aid != eid || irq_req[c] != ereq) begin
            n_bad++;
            $display("FAIL %s cpu%0d: id=%0d req=%0b expected id=%0d req=%0b",
                     tag, c, aid, irq_req[c], eid, ereq);
        end
    endtask

    // Let one edge pass, then compare every CPU against the reference.
    task automatic step_check(string tag);
        int  eid;
        bit  ereq;
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            ref_calc(c, eid, ereq);
            cmp_cpu(c, eid, ereq, tag);
        end
    endtask

    task automatic clear_all();
        dist_en = 1'b1; cpu_en = '1; src_en = '0; pend = '0;
        prio_bank = '1; prio_shared = '1;
        prio_mask = {NC{8'hFF}}; run_prio = {NC{9'h100}};
    endtask

    task automatic set_shared(int s, int p);
        prio_shared[(s-NB)*8 +: 8] = 8'(p);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        clear_all();
        rst_n = 1'b0;
        pend  = '1; src_en = '1;
        @(negedge clk); @(negedge clk);
        // R1: reset holds outputs idle even with pending sources
        for (int c = 0; c < NC; c++) cmp_cpu(c, SP, 1'b0, "R1 reset");
        rst_n = 1'b1;
        clear_all();
        step_check("R4 nothing pending");

        // R2: pending only for cpu0; then disable the source
        src_en[40] = 1'b1; set_shared(40, 8'h30); pend[0*NS+40] = 1'b1;
        step_check("R2 cpu0 only");
        src_en[40] = 1'b0;
        step_check("R2 source disabled");

        // R3: tie goes to lower ID, then strictly smaller wins
        src_en[40] = 1'b1; src_en[50] = 1'b1;
        set_shared(40, 8'h20); set_shared(50, 8'h20);
        pend[40] = 1'b1; pend[50] = 1'b1; pend[NS+40] = 1'b1; pend[NS+50] = 1'b1;
        step_check("R3 tie lowest id");
        set_shared(50, 8'h1F);
        step_check("R3 smaller value wins");

        // R5: mask equal passes, one below hides
        prio_mask[7:0] = 8'h1F;
        step_check("R5 mask equal");
        prio_mask[7:0] = 8'h1E;
        step_check("R5 mask below");
        prio_mask[7:0] = 8'hFF;

        // R6 / R7: preemption threshold against running priority
        run_prio[8:0] = 9'h020;
        step_check("R6 preempts");
        run_prio[8:0] = 9'h01F;
        step_check("R7 equal no preempt");
        run_prio[8:0] = 9'h100; set_shared(50, 8'hFF); set_shared(40, 8'hFF);
        step_check("R6 idle vs 0xFF");

        // R8 / R9: enables
        dist_en = 1'b0;
        step_check("R8 dist off");
        dist_en = 1'b1; cpu_en = 2'b01;
        step_check("R9 cpu1 off");
        cpu_en = '1;

        // R10: banked source differs per CPU, shared one in between
        clear_all();
        src_en[5] = 1'b1; src_en[40] = 1'b1;
        pend[5] = 1'b1; pend[40] = 1'b1; pend[NS+5] = 1'b1; pend[NS+40] = 1'b1;
        prio_bank[(0*NB+5)*8 +: 8] = 8'h10;
        prio_bank[(1*NB+5)*8 +: 8] = 8'h90;
        set_shared(40, 8'h50);
        step_check("R10 banked vs shared");

        // R11: change input, old result still held before the edge
        prio_bank[(1*NB+5)*8 +: 8] = 8'h05;
        #1;
        cmp_cpu(1, 40, 1'b1, "R11 held before edge");
        step_check("R11 updated after edge");

        // Random vectors covering R2, R3, R5, R6, R7
        for (int v = 0; v < 600; v++) begin
            bit narrow = ($urandom % 2) == 0;
            dist_en = ($urandom % 16) != 0;
            cpu_en  = NC'(($urandom % 8 == 0) ? $urandom : '1);
            src_en  = {$urandom, $urandom} | {$urandom, $urandom};
            pend    = {$urandom, $urandom, $urandom, $urandom}
                    & {$urandom, $urandom, $urandom, $urandom}
                    & {$urandom, $urandom, $urandom, $urandom};
            for (int i = 0; i < NC*NB; i++)
                prio_bank[i*8 +: 8] = 8'(narrow ? ($urandom % 4) << 4 : $urandom);
            for (int i = 0; i < NS-NB; i++)
                prio_shared[i*8 +: 8] = 8'(narrow ? ($urandom % 4) << 4 : $urandom);
            for (int c = 0; c < NC; c++) begin
                prio_mask[c*8 +: 8] = 8'(($urandom % 2) ? 8'hFF : $urandom);
                run_prio[c*9 +: 9]  = 9'(($urandom % 3 == 0) ? 9'h100 : ($urandom % 256));
            end
            step_check("R2,R3,R5,R6,R7 random");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule